// File: doc/BRIEF.md
# Receive-Side Credit Grant Tracker

This block keeps the credit accounting for one packet category on the receive side of a packetized serial link, for example the posted-write class. It has two lanes of accounting. One lane counts packet headers, with one credit per header. The other lane counts payload, with one credit per 128-bit unit. For each lane it keeps the buffer occupancy, a running total of credits received, and a running total of credits returned by the application. From these it derives the cumulative grant that can be offered to the link partner. That grant is the initial allowance plus everything drained so far. It wraps modulo 256 for headers and modulo 4096 for payload.

During the initialization phase the advertised fields follow the live grant, so the framing logic outside can send them as the starting allowance. After initialization the advertised fields are frozen between updates. An update is raised in two cases. The first is when a programmable number of microsecond ticks has passed since the last accepted update. The second is at once, when the partner's advertised headroom has fallen below one packet and draining has made room again. The update request is a valid/ready pair. Once `upd_valid` rises it stays high, and both fields stay fixed, until the consumer asserts `upd_ready`. The request drops on that edge. Either lane can be configured as unlimited. An unlimited lane advertises zero and never reports overflow. When both lanes are unlimited, no update is ever requested. A packet that arrives beyond the advertised headroom sets a sticky overflow flag for its lane.

Top module: `rx_credit_issuer`

## Requirements
- R1: After reset, with a lane not unlimited, `hdr_fc` reads HDR_DEPTH (63 by default) and `dat_fc` reads DAT_DEPTH (511 by default). `upd_valid`, `hdr_ovf` and `dat_ovf` are 0.
- R2: Each field equals the initial allowance plus all credits released on that lane, modulo 256 for `hdr_fc` and 4096 for `dat_fc`. For example, an initial 511 followed by releasing 16 units advertises 527.
- R3: Advertised headroom (the advertised total minus the received total) plus occupancy never exceeds the smaller of the buffer depth and the outstanding limit (127 headers, 2047 units). An arrival that exactly uses up the headroom is not an overflow.
- R4: A lane with its unlimited bit set reads 0 and never raises its overflow flag. With both bits set, `upd_valid` never rises.
- R5: While `init_phase` is 1, each field takes the live grant two clock edges after a release strobe, and no update is requested.
- R6: After initialization, with no other trigger, `upd_valid` rises on the edge of the PERIOD_US-th `us_tick` counted since the last accepted update, or since leaving reset. The fields then show the live grant.
- R7: When a lane's advertised headroom is below its threshold (1 header, or MAXPKT_UNITS units) and its live headroom is at or above it, `upd_valid` rises on the second edge after the release that caused it.
- R8: While `upd_valid` is 1 and `upd_ready` is 0, `upd_valid`, `hdr_fc` and `dat_fc` hold. `upd_valid` falls on the edge where `upd_ready` is 1.
- R9: An arrival larger than the lane's advertised headroom sets that lane's overflow flag, which stays set until reset.
- R10: Outside initialization, releases and arrivals leave `hdr_fc` and `dat_fc` unchanged until an update is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_phase | input | 1 | 1 while the starting allowance is being advertised |
| cfg_inf_hdr | input | 1 | Header lane is unlimited; hold stable outside reset |
| cfg_inf_dat | input | 1 | Payload lane is unlimited; hold stable outside reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| arr_hdr | input | 1 | One header arrived this cycle |
| arr_units | input | UW | Payload units arrived this cycle (0 = none) |
| rel_hdr | input | 1 | Application drained one header this cycle |
| rel_units | input | UW | Payload units drained this cycle (0 = none) |
| upd_ready | input | 1 | Consumer takes the pending update |
| upd_valid | output | 1 | Update request, held until accepted |
| hdr_fc | output | 8 | Advertised cumulative header credits |
| dat_fc | output | 12 | Advertised cumulative payload credits |
| hdr_ovf | output | 1 | Sticky header overflow |
| dat_ovf | output | 1 | Sticky payload overflow |

## Verification
The assertions assume three things about the inputs. The application never drains more than the buffer holds, counting what arrives in the same cycle. The unlimited configuration bits change only during reset. No checks on occupancy or headroom apply once a lane has overflowed or is unlimited. The stimulus respects these assumptions. Every release in the bench is preceded by, or paired with, an arrival of at least the same size. Configuration is changed only while reset is asserted. Deliberate overflows are placed at the end of a scenario, just before a fresh reset.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam int HDR_FC_W    = 8;
  localparam int DAT_FC_W    = 12;
  localparam int HDR_OUT_MAX = 127;
  localparam int DAT_OUT_MAX = 2047;

  function automatic int cap_of(input int depth, input int limit);
    return (depth < limit) ? depth : limit;
  endfunction
endpackage

// File: rtl/fcc_lane.sv
module fcc_lane import fcc_pkg::*; #(
  parameter int W     = 8,
  parameter int DEPTH = 63,
  parameter int LIMIT = 127,
  parameter int THR   = 1,
  parameter int NW    = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inf,
  input  logic          track,
  input  logic          latch,
  input  logic [NW-1:0] arr_n,
  input  logic [NW-1:0] rel_n,
  output logic [W-1:0]  fc,
  output logic          starve_fix,
  output logic          ovf
);
  localparam int CAP = cap_of(DEPTH, LIMIT);
  localparam int OW  = $clog2(CAP + 1) + 1;
  localparam logic [W-1:0] CAP_W = W'(CAP);
  localparam logic [W-1:0] THR_W = W'(THR);

  logic [W-1:0]  rel_tot, rcv_tot, adv;
  logic [W-1:0]  live, adv_head, live_head;
  logic [OW-1:0] occ;
  logic          ovf_q;

  // Grant is always the drained total plus the fixed allowance.
  assign live      = rel_tot + CAP_W;
  assign adv_head  = adv - rcv_tot;
  assign live_head = live - rcv_tot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_tot <= '0;
      rcv_tot <= '0;
      adv     <= CAP_W;
      occ     <= '0;
      ovf_q   <= 1'b0;
    end else begin
      rcv_tot <= rcv_tot + W'(arr_n);
      rel_tot <= rel_tot + W'(rel_n);
      occ     <= occ + OW'(arr_n) - OW'(rel_n);
      if (track || latch)
        adv <= live;
      if (!inf && (W'(arr_n) > adv_head))
        ovf_q <= 1'b1;
    end
  end

  assign starve_fix = !inf && (adv_head < THR_W) && (live_head >= THR_W);
  assign fc         = inf ? '0 : adv;
  assign ovf        = ovf_q;

  // R3: offered headroom plus held entries stays within the allowance
  p_grant_cap_r3: assert property (@(posedge clk) disable iff (!rst_n || ovf_q || inf)
    (int'(occ) + int'(adv_head)) <= CAP);

  // R2: drains never exceed what the buffer holds (input assumption)
  p_rel_within_occ_r2: assert property (@(posedge clk) disable iff (!rst_n || ovf_q || inf)
    int'(rel_n) <= (int'(occ) + int'(arr_n)));

  // R9: overflow flag is sticky
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  // R10: advertised total frozen unless tracking or latching
  p_adv_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!track && !latch) |=> $stable(adv));
endmodule

// File: rtl/fcc_sched.sv
module fcc_sched #(
  parameter int PERIOD_US = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic silent,
  input  logic tick,
  input  logic starve,
  input  logic ready,
  output logic valid,
  output logic latch
);
  localparam int TW = (PERIOD_US > 1) ? $clog2(PERIOD_US) : 1;
  localparam logic [TW-1:0] LAST = TW'(PERIOD_US - 1);

  logic [TW-1:0] timer;
  logic          valid_q;
  logic          due;

  assign due   = tick && (timer == LAST);
  assign latch = !init && !silent && !valid_q && (starve || due);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      timer   <= '0;
    end else if (latch) begin
      valid_q <= 1'b1;
      timer   <= '0;
    end else if (valid_q && ready) begin
      valid_q <= 1'b0;
      timer   <= '0;
    end else if (init) begin
      timer   <= '0;
    end else if (tick && (timer != LAST)) begin
      timer   <= timer + 1'b1;
    end
  end

  assign valid = valid_q;

  // R6: the interval counter never runs past its deadline
  p_timer_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    timer <= LAST);

  // R5: no request starts from a cycle spent in initialization
  p_init_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> !$rose(valid_q));

  // R4: a fully unlimited category stays silent
  p_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    silent |=> !$rose(valid_q));

  // R8: a pending request is only withdrawn by acceptance
  p_hold_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready) |=> valid_q);
endmodule

// File: rtl/rx_credit_issuer.sv
module rx_credit_issuer import fcc_pkg::*; #(
  parameter int HDR_DEPTH    = 63,
  parameter int DAT_DEPTH    = 511,
  parameter int MAXPKT_UNITS = 32,
  parameter int PERIOD_US    = 30,
  localparam int UW          = $clog2(MAXPKT_UNITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init_phase,
  input  logic                cfg_inf_hdr,
  input  logic                cfg_inf_dat,
  input  logic                us_tick,
  input  logic                arr_hdr,
  input  logic [UW-1:0]       arr_units,
  input  logic                rel_hdr,
  input  logic [UW-1:0]       rel_units,
  input  logic                upd_ready,
  output logic                upd_valid,
  output logic [HDR_FC_W-1:0] hdr_fc,
  output logic [DAT_FC_W-1:0] dat_fc,
  output logic                hdr_ovf,
  output logic                dat_ovf
);
  logic h_starve, d_starve, latch;

  fcc_lane #(
    .W(HDR_FC_W), .DEPTH(HDR_DEPTH), .LIMIT(HDR_OUT_MAX), .THR(1), .NW(1)
  ) u_hdr (
    .clk(clk), .rst_n(rst_n), .inf(cfg_inf_hdr), .track(init_phase),
    .latch(latch), .arr_n(arr_hdr), .rel_n(rel_hdr),
    .fc(hdr_fc), .starve_fix(h_starve), .ovf(hdr_ovf)
  );

  fcc_lane #(
    .W(DAT_FC_W), .DEPTH(DAT_DEPTH), .LIMIT(DAT_OUT_MAX), .THR(MAXPKT_UNITS), .NW(UW)
  ) u_dat (
    .clk(clk), .rst_n(rst_n), .inf(cfg_inf_dat), .track(init_phase),
    .latch(latch), .arr_n(arr_units), .rel_n(rel_units),
    .fc(dat_fc), .starve_fix(d_starve), .ovf(dat_ovf)
  );

  fcc_sched #(.PERIOD_US(PERIOD_US)) u_sched (
    .clk(clk), .rst_n(rst_n), .init(init_phase),
    .silent(cfg_inf_hdr && cfg_inf_dat), .tick(us_tick),
    .starve(h_starve || d_starve), .ready(upd_ready),
    .valid(upd_valid), .latch(latch)
  );

  // R8: fields stay put while an update waits for acceptance
  p_fields_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_ready) |=> (upd_valid && $stable(hdr_fc) && $stable(dat_fc)));
endmodule

// File: tb/sim_rx_credit_issuer.sv
`timescale 1ns/1ps
module sim_rx_credit_issuer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_phase = 1'b1, cfg_inf_hdr = 1'b0, cfg_inf_dat = 1'b0, us_tick = 1'b0;
  logic arr_hdr = 1'b0, rel_hdr = 1'b0, upd_ready = 1'b0;
  logic [5:0] arr_units = '0, rel_units = '0;
  logic upd_valid, hdr_ovf, dat_ovf;
  logic [7:0] hdr_fc;
  logic [11:0] dat_fc;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rx_credit_issuer u0 (
    .clk(clk), .rst_n(rst_n), .init_phase(init_phase), .cfg_inf_hdr(cfg_inf_hdr),
    .cfg_inf_dat(cfg_inf_dat), .us_tick(us_tick), .arr_hdr(arr_hdr),
    .arr_units(arr_units), .rel_hdr(rel_hdr), .rel_units(rel_units),
    .upd_ready(upd_ready), .upd_valid(upd_valid), .hdr_fc(hdr_fc),
    .dat_fc(dat_fc), .hdr_ovf(hdr_ovf), .dat_ovf(dat_ovf)
  );

  typedef struct packed {
    logic [15:0] rep;
    logic        ah;
    logic [5:0]  au;
    logic        rh;
    logic [5:0]  ru;
    logic        tk;
    logic        rdy;
    logic        ev;
    logic [7:0]  eh;
    logic [11:0] ed;
    logic        eo;
  } row_t;

  // Starts after reset with the allowance 63 / 511 and initialization left.
  localparam row_t TBL [12] = '{
    '{16'd15, 1'b1, 6'd32, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 8'd63, 12'd511, 1'b0}, // R10 fill
    '{16'd1,  1'b0, 6'd0,  1'b1, 6'd16, 1'b0, 1'b0, 1'b1, 8'd64, 12'd527, 1'b0}, // R7 starve fix
    '{16'd1,  1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 8'd64, 12'd527, 1'b0}, // R8 accept
    '{16'd29, 1'b0, 6'd0,  1'b0, 6'd0,  1'b1, 1'b0, 1'b0, 8'd64, 12'd527, 1'b0}, // R6 not yet due
    '{16'd1,  1'b0, 6'd0,  1'b0, 6'd0,  1'b1, 1'b0, 1'b1, 8'd64, 12'd527, 1'b0}, // R6 due
    '{16'd1,  1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 8'd64, 12'd527, 1'b0}, // R8 accept
    '{16'd14, 1'b0, 6'd0,  1'b1, 6'd32, 1'b0, 1'b0, 1'b0, 8'd64, 12'd527, 1'b0}, // R10 drains held
    '{16'd30, 1'b0, 6'd0,  1'b0, 6'd0,  1'b1, 1'b0, 1'b1, 8'd78, 12'd975, 1'b0}, // R6 new totals
    '{16'd1,  1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 8'd78, 12'd975, 1'b0}, // R8 accept
    '{16'd15, 1'b1, 6'd32, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 8'd78, 12'd975, 1'b0}, // R3 refill
    '{16'd1,  1'b1, 6'd15, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 8'd78, 12'd975, 1'b0}, // R3 exact fit
    '{16'd1,  1'b0, 6'd1,  1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 8'd78, 12'd975, 1'b1}  // R9 one too many
  };
  string tags [12] = '{"R10", "R7", "R8", "R6", "R6", "R8", "R10", "R6", "R8", "R3", "R3", "R9"};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic ah, input logic [5:0] au, input logic rh,
                       input logic [5:0] ru, input logic tk, input logic rdy);
    arr_hdr = ah; arr_units = au; rel_hdr = rh; rel_units = ru;
    us_tick = tk; upd_ready = rdy;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 1'b0);
  endtask

  task automatic do_reset(input logic ini, input logic ih, input logic id);
    rst_n = 1'b0; init_phase = ini; cfg_inf_hdr = ih; cfg_inf_dat = id;
    idle(3);
    rst_n = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    do_reset(1'b1, 1'b0, 1'b0);
    // R1 reset state
    chk("R1 hdr_fc", hdr_fc, 63);
    chk("R1 dat_fc", dat_fc, 511);
    chk("R1 upd_valid", upd_valid, 0);
    chk("R1 hdr_ovf", hdr_ovf, 0);
    chk("R1 dat_ovf", dat_ovf, 0);
    init_phase = 1'b0;

    for (int i = 0; i < 12; i++) begin
      for (int k = 0; k < int'(TBL[i].rep); k++)
        drive(TBL[i].ah, TBL[i].au, TBL[i].rh, TBL[i].ru, TBL[i].tk, TBL[i].rdy);
      idle(1);
      chk($sformatf("%s row%0d upd_valid", tags[i], i), upd_valid, TBL[i].ev);
      chk($sformatf("%s row%0d hdr_fc", tags[i], i), hdr_fc, TBL[i].eh);
      chk($sformatf("%s row%0d dat_fc", tags[i], i), dat_fc, TBL[i].ed);
      chk($sformatf("%s row%0d dat_ovf", tags[i], i), dat_ovf, TBL[i].eo);
      chk($sformatf("%s row%0d hdr_ovf", tags[i], i), hdr_ovf, 0);
    end

    // R5: initialization tracks the live grant and stays quiet
    do_reset(1'b1, 1'b0, 1'b0);
    drive(1'b1, 6'd8, 1'b0, 6'd0, 1'b0, 1'b0);
    drive(1'b0, 6'd0, 1'b1, 6'd8, 1'b0, 1'b0);
    idle(1);
    chk("R5 init hdr_fc", hdr_fc, 64);
    chk("R5 init dat_fc", dat_fc, 519);
    for (int k = 0; k < 30; k++) drive(1'b0, 6'd0, 1'b0, 6'd0, 1'b1, 1'b0);
    idle(1);
    chk("R5 no update in init", upd_valid, 0);
    init_phase = 1'b0;

    // R2: modular wrap of both totals under steady traffic
    for (int k = 0; k < 300; k++) drive(1'b1, 6'd16, 1'b1, 6'd16, 1'b0, 1'b1);
    for (int k = 0; k < 2; k++) drive(1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 1'b1);
    chk("R9 no overflow under updates", dat_ovf, 0);
    for (int k = 0; k < 30; k++) drive(1'b0, 6'd0, 1'b0, 6'd0, 1'b1, 1'b0);
    idle(1);
    chk("R6 wrap update", upd_valid, 1);
    chk("R2 hdr_fc wraps", hdr_fc, 108);
    chk("R2 dat_fc wraps", dat_fc, 1223);

    // R4: both lanes unlimited
    do_reset(1'b0, 1'b1, 1'b1);
    chk("R4 hdr_fc zero", hdr_fc, 0);
    chk("R4 dat_fc zero", dat_fc, 0);
    for (int k = 0; k < 200; k++) drive(1'b1, 6'd63, 1'b0, 6'd0, 1'b0, 1'b0);
    for (int k = 0; k < 40; k++) drive(1'b0, 6'd0, 1'b0, 6'd0, 1'b1, 1'b0);
    idle(1);
    chk("R4 no update", upd_valid, 0);
    chk("R4 no hdr_ovf", hdr_ovf, 0);
    chk("R4 no dat_ovf", dat_ovf, 0);

    // R4 payload unlimited only; R9 header overflow stays set
    do_reset(1'b0, 1'b0, 1'b1);
    chk("R4 hdr_fc finite", hdr_fc, 63);
    chk("R4 dat_fc zero", dat_fc, 0);
    for (int k = 0; k < 30; k++) drive(1'b0, 6'd0, 1'b0, 6'd0, 1'b1, 1'b0);
    idle(1);
    chk("R6 update with one lane unlimited", upd_valid, 1);
    chk("R4 dat_fc still zero", dat_fc, 0);
    drive(1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 1'b1);
    for (int k = 0; k < 63; k++) drive(1'b1, 6'd0, 1'b0, 6'd0, 1'b0, 1'b0);
    idle(1);
    chk("R3 all header credits used", hdr_ovf, 0);
    drive(1'b1, 6'd0, 1'b0, 6'd0, 1'b0, 1'b0);
    idle(1);
    chk("R9 hdr_ovf set", hdr_ovf, 1);
    for (int k = 0; k < 30; k++) drive(1'b0, 6'd0, 1'b0, 6'd0, 1'b1, 1'b0);
    drive(1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 1'b1);
    idle(2);
    chk("R9 hdr_ovf sticky", hdr_ovf, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule